// File: doc/BRIEF.md
# Dual-Channel Rectifier Mode Controller

This block is the supervisory state machine that sits above two synchronous-rectifier gate sequencers. It takes a supply indication whose turn-on and lockout levels have already been applied, one pulse per channel each time that channel's drain voltage crosses the positive re-arm threshold, and one end-of-conduction report per channel that says whether the last conduction was shorter than the minimum on time. It passes each sequencer's gate request through to a registered gate output. It only does this when the supervisory state allows it, and only when the other channel's gate is low.

After the supply comes up, the controller holds both gates off until it has seen two drain edges. Gating therefore always starts at the beginning of a whole switching cycle. A short conduction on a channel puts that channel into skip: its next gate pulses are suppressed, while its sequencer keeps measuring. A longer conduction later clears the skip. If no drain edge arrives for a fixed number of cycles, the controller goes to sleep. The next edge wakes it into the synchronising state again.

Internal states and the transitions between them:
- UVLO → SYNC when the supply is above the turn-on level.
- SLEEP_IDLE → SYNC on any drain edge.
- SYNC → RUN on the second counted edge.
- SYNC, RUN and SKIP → SLEEP_IDLE on the wait timeout.
- RUN ↔ SKIP as the per-channel skip flags set and clear.
- Any state → UVLO when the supply falls below the lockout level.

Top module: `sr_mode_ctrl`

## Requirements
- R1: While `supply_lost_i` is low, the controller stays in the power-up lockout state until `supply_on_i` is high. It then moves to synchronising. `mode_o` encodes the state as follows:
  - 2'b00: lockout or sleep
  - 2'b01: synchronising
  - 2'b10: normal
  - 2'b11: protection
- R2: When `supply_lost_i` is high, the next cycle shows `mode_o`=00 and `gate_o`=00, whatever the previous state was.
- R3: In synchronising, both gates stay low and `suppress_o` is 11. The clock edge that samples the second `rearm_edge_i` pulse moves the mode to 10. The edge count is cleared on every entry to mode 00.
- R4: In modes 01, 10 and 11, WAIT_CYC consecutive cycles without any `rearm_edge_i` pulse put the controller into sleep (mode 00). Any edge restarts that count.
- R5: From sleep, a `rearm_edge_i` pulse on either channel moves the mode to 01. That waking edge is not counted, so two further edges are needed to reach mode 10.
- R6: A `cond_done_i[k]` pulse with `cond_short_i[k]` high sets channel k's skip flag. This gives mode 11 and `suppress_o[k]`=1, and holds `gate_o[k]` low. The other channel keeps gating.
- R7: A `cond_done_i[k]` pulse with `cond_short_i[k]` low clears channel k's skip flag. With no flag set, the mode returns to 10.
- R8: `gate_o[0]` and `gate_o[1]` are never high in the same cycle.
- R9: If both channels are allowed in the same cycle, a channel whose gate is already high keeps it. If neither gate is high, channel 1 (bit 0) wins and channel 2 waits until channel 1 drops.
- R10: In modes 10 and 11, a channel that is not skipped and wins the interlock drives `gate_o[k]`. `gate_o[k]` follows `gate_req_i[k]` one clock later. `suppress_o[k]` is 1 exactly when channel k may not gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_on_i | input | 1 | Supply above turn-on level |
| supply_lost_i | input | 1 | Supply below lockout level |
| rearm_edge_i | input | 2 | One-cycle pulse per channel on a re-arm threshold crossing |
| cond_done_i | input | 2 | One-cycle pulse per channel at the end of a conduction |
| cond_short_i | input | 2 | Qualifies `cond_done_i`: the conduction was shorter than the minimum on time |
| gate_req_i | input | 2 | Gate request from each sequencer |
| gate_o | output | 2 | Interlocked, registered gate enable per channel |
| suppress_o | output | 2 | Channel may not gate (skip or inactive mode) |
| mode_o | output | 2 | Mode status: 00 sleep/lockout, 01 sync, 10 normal, 11 protection |

## Verification
The following properties are checked on every cycle by assertions:
- The gates never overlap.
- A high gate was requested in the cycle before.
- A suppressed channel never gates.
- A supply loss always lands in mode 00 with both gates low.
- Leaving synchronisation for normal requires a drain edge.
- The edge and wait counters stay inside their ranges.

The bench's directed scenarios cover the rest:
- the count of two edges;
- the edge count being cleared by a supply loss in mid-synchronisation;
- the exact length of the edge-free timeout and its restart;
- a waking edge not counting towards synchronisation;
- which channel wins a simultaneous request;
- a skipped channel resuming after a long conduction.

// File: rtl/sr_mode_pkg.sv
package sr_mode_pkg;

    typedef enum logic [2:0] {
        ST_UVLO,
        ST_IDLE,
        ST_SYNC,
        ST_RUN,
        ST_SKIP
    } ctl_state_e;

    localparam logic [1:0] MODE_SLEEP = 2'b00;
    localparam logic [1:0] MODE_SYNC  = 2'b01;
    localparam logic [1:0] MODE_RUN   = 2'b10;
    localparam logic [1:0] MODE_SKIP  = 2'b11;

    function automatic logic [1:0] mode_of(ctl_state_e s);
        logic [1:0] m;
        unique case (s)
            ST_SYNC: m = MODE_SYNC;
            ST_RUN:  m = MODE_RUN;
            ST_SKIP: m = MODE_SKIP;
            default: m = MODE_SLEEP;
        endcase
        return m;
    endfunction

    function automatic logic is_awake(ctl_state_e s);
        return (s == ST_SYNC) || (s == ST_RUN) || (s == ST_SKIP);
    endfunction

    function automatic logic is_gating(ctl_state_e s);
        return (s == ST_RUN) || (s == ST_SKIP);
    endfunction

endpackage

// File: rtl/sr_wait_timer.sv
module sr_wait_timer #(
    parameter int WAIT_CYC = 28500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic restart,
    output logic expired
);
    localparam int TW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign expired = count_en && !restart && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!count_en || restart || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/sr_sync_count.sv
module sr_sync_count #(
    parameter int SYNC_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic clear,
    input  logic edge_seen,
    output logic hit
);
    localparam int CW = $clog2(SYNC_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_EDGES - 1);

    logic [CW-1:0] cnt_q;

    assign hit = count_en && edge_seen && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (count_en && edge_seen && !hit)
            cnt_q <= cnt_q + 1'b1;
    end

    // R3
    sync_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/sr_skip_flag.sv
module sr_skip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic active_q,
    input  logic keep,
    input  logic done,
    input  logic short_i,
    output logic flag_d,
    output logic flag_q
);
    always_comb begin
        if (!active_q)
            flag_d = 1'b0;
        else if (done)
            flag_d = short_i;
        else
            flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= keep ? flag_d : 1'b0;
    end

    // R6
    skip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && keep && done && short_i) |=> flag_q);

    // R7
    skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !short_i) |=> !flag_q);

endmodule

// File: rtl/sr_gate_interlock.sv
module sr_gate_interlock (
    input  logic [1:0] allow,
    input  logic [1:0] held,
    output logic [1:0] grant
);
    always_comb begin
        if (allow == 2'b11)
            grant = (held[1] && !held[0]) ? 2'b10 : 2'b01;
        else
            grant = allow;
    end
endmodule

// File: rtl/sr_mode_ctrl.sv
module sr_mode_ctrl
    import sr_mode_pkg::*;
#(
    parameter int WAIT_CYC   = 28500,
    parameter int SYNC_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_on_i,
    input  logic       supply_lost_i,
    input  logic [1:0] rearm_edge_i,
    input  logic [1:0] cond_done_i,
    input  logic [1:0] cond_short_i,
    input  logic [1:0] gate_req_i,
    output logic [1:0] gate_o,
    output logic [1:0] suppress_o,
    output logic [1:0] mode_o
);
    localparam int NCH = 2;

    ctl_state_e state_q, state_d;
    logic any_edge, tmr_expired, sync_hit;
    logic gating_q, gating_d;
    logic [NCH-1:0] skip_d, skip_q, allow, grant, gate_q;

    assign any_edge = |rearm_edge_i;
    assign gating_q = is_gating(state_q);
    assign gating_d = is_gating(state_d);

    sr_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (is_awake(state_q)),
        .restart  (any_edge),
        .expired  (tmr_expired)
    );

    sr_sync_count #(.SYNC_EDGES(SYNC_EDGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (state_q == ST_SYNC),
        .clear     (!is_awake(state_d)),
        .edge_seen (any_edge),
        .hit       (sync_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        sr_skip_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_q (gating_q),
            .keep     (gating_d),
            .done     (cond_done_i[g]),
            .short_i  (cond_short_i[g]),
            .flag_d   (skip_d[g]),
            .flag_q   (skip_q[g])
        );

        // R6
        skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            suppress_o[g] |-> !gate_o[g]);

        // R10
        gate_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_o[g] |-> $past(gate_req_i[g]));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (supply_lost_i) begin
            state_d = ST_UVLO;
        end else begin
            unique case (state_q)
                ST_UVLO: if (supply_on_i) state_d = ST_SYNC;
                ST_IDLE: if (any_edge)    state_d = ST_SYNC;
                ST_SYNC: begin
                    if (tmr_expired)   state_d = ST_IDLE;
                    else if (sync_hit) state_d = ST_RUN;
                end
                ST_RUN, ST_SKIP: begin
                    if (tmr_expired) state_d = ST_IDLE;
                    else             state_d = (|skip_d) ? ST_SKIP : ST_RUN;
                end
                default: state_d = ST_UVLO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_UVLO;
        else
            state_q <= state_d;
    end

    // Gate path: allowed by next state, interlocked, registered
    assign allow = gate_req_i & ~skip_d & {NCH{gating_d}};

    sr_gate_interlock u_lock (
        .allow (allow),
        .held  (gate_q),
        .grant (grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gate_q <= '0;
        else
            gate_q <= grant;
    end

    // Outputs
    always_comb begin
        gate_o     = gate_q;
        suppress_o = skip_q | {NCH{!gating_q}};
        mode_o     = mode_of(state_q);
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[1]));

    // R2
    uvlo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lost_i |=> (mode_o == MODE_SLEEP && gate_o == 2'b00));

    // R3
    sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && $past(mode_o) == MODE_SYNC) |-> $past(any_edge));

endmodule

// File: tb/sr_mode_ctrl_test.sv
module sr_mode_ctrl_test;
    localparam int WAIT = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_on = 1'b0, supply_lost = 1'b0;
    logic [1:0] rearm = '0, done = '0, shrt = '0, req = '0;
    logic [1:0] gate, supp, mode;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    sr_mode_ctrl #(.WAIT_CYC(WAIT), .SYNC_EDGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .supply_on_i(supply_on), .supply_lost_i(supply_lost),
        .rearm_edge_i(rearm), .cond_done_i(done), .cond_short_i(shrt),
        .gate_req_i(req), .gate_o(gate), .suppress_o(supp), .mode_o(mode)
    );

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_edge(input logic [1:0] e);
        rearm = e;
        tick(1);
        rearm = '0;
    endtask

    task automatic t_reset;
        chk("R1 reset mode", mode, 2'b00);
        chk("R1 reset gate", gate, 2'b00);
        chk("R10 reset suppress", supp, 2'b11);
    endtask

    task automatic t_uvlo_hold;
        req = 2'b11;
        pulse_edge(2'b01);
        pulse_edge(2'b10);
        chk("R1 held in lockout", mode, 2'b00);
        chk("R1 no gate in lockout", gate, 2'b00);
        req = '0;
    endtask

    task automatic t_sync;
        supply_on = 1'b1;
        tick(1);
        chk("R1 leave lockout", mode, 2'b01);
        req = 2'b01;
        pulse_edge(2'b01);
        chk("R3 one edge", mode, 2'b01);
        chk("R3 gate off in sync", gate, 2'b00);
        chk("R3 suppress in sync", supp, 2'b11);
        pulse_edge(2'b10);
        chk("R3 second edge", mode, 2'b10);
        chk("R10 gate follows", gate, 2'b01);
        chk("R10 suppress clear", supp, 2'b00);
        req = '0;
        tick(1);
        chk("R10 gate drops", gate, 2'b00);
    endtask

    task automatic t_interlock;
        pulse_edge(2'b11);
        req = 2'b11;
        tick(1);
        chk("R9 ch1 wins tie", gate, 2'b01);
        tick(1);
        chk("R8 no overlap", gate, 2'b01);
        req = 2'b10;
        tick(1);
        chk("R9 ch2 after ch1 drops", gate, 2'b10);
        req = 2'b11;
        tick(1);
        chk("R9 ch2 keeps priority", gate, 2'b10);
        req = '0;
        tick(1);
    endtask

    task automatic t_prot;
        pulse_edge(2'b11);
        done = 2'b01; shrt = 2'b01;
        tick(1);
        done = '0; shrt = '0;
        chk("R6 protection mode", mode, 2'b11);
        chk("R6 suppress ch1", supp, 2'b01);
        req = 2'b01;
        tick(1);
        chk("R6 ch1 skipped", gate, 2'b00);
        req = 2'b10;
        tick(1);
        chk("R6 ch2 unaffected", gate, 2'b10);
        req = '0;
        tick(1);
        req = 2'b01; done = 2'b01;
        tick(1);
        done = '0;
        chk("R7 back to normal", mode, 2'b10);
        chk("R7 ch1 gates again", gate, 2'b01);
        req = '0;
        tick(1);
    endtask

    task automatic t_timeout;
        for (int i = 0; i < 3; i++) begin
            tick(300);
            pulse_edge(2'b01);
        end
        chk("R4 edges restart timer", mode, 2'b10);
        tick(WAIT - 10);
        chk("R4 before timeout", mode, 2'b10);
        tick(20);
        chk("R4 timeout sleep", mode, 2'b00);
        chk("R4 suppress in sleep", supp, 2'b11);
    endtask

    task automatic t_wake;
        req = 2'b01;
        pulse_edge(2'b10);
        chk("R5 wake to sync", mode, 2'b01);
        chk("R5 gate off after wake", gate, 2'b00);
        pulse_edge(2'b01);
        chk("R5 wake edge not counted", mode, 2'b01);
        pulse_edge(2'b01);
        chk("R5 normal after two edges", mode, 2'b10);
        chk("R5 gating resumes", gate, 2'b01);
        req = '0;
        tick(1);
    endtask

    task automatic t_supply_loss;
        req = 2'b10;
        tick(1);
        chk("R10 ch2 gating", gate, 2'b10);
        supply_lost = 1'b1; supply_on = 1'b0;
        tick(1);
        chk("R2 lockout on loss", mode, 2'b00);
        chk("R2 gates off on loss", gate, 2'b00);
        supply_lost = 1'b0; supply_on = 1'b1;
        tick(1);
        pulse_edge(2'b01);
        chk("R3 one edge counted", mode, 2'b01);
        supply_lost = 1'b1; supply_on = 1'b0;
        tick(1);
        supply_lost = 1'b0; supply_on = 1'b1;
        tick(1);
        pulse_edge(2'b01);
        chk("R3 count cleared by lockout", mode, 2'b01);
        pulse_edge(2'b10);
        chk("R3 normal after fresh count", mode, 2'b10);
        req = '0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_uvlo_hold();
        t_sync();
        t_interlock();
        t_prot();
        t_timeout();
        t_wake();
        t_supply_loss();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule